// File: doc/BRIEF.md
# Predictive Synchronous-Rectifier Gate Timer

This block produces the gate-enable bit for a secondary-side synchronous rectifier in a flyback converter. The rectifier clock arrives as a digitised level that is high while the primary switch conducts. The gate is driven as the complement of that level, with one change: each gate pulse ends a few ticks before the clock is expected to rise again. Every tick is one period of the block's fast clock (about 15 MHz). The block predicts the end of the low phase from the length of the previous low phase, counted in ticks, and subtracts an anticipation of 2, 3 or 5 ticks chosen by a 2-bit select.

Three further conditions end a pulse or block it. A digitised reverse-current flag can end a pulse early so that discontinuous conduction works. This flag is ignored for a blanking window after each turn-on, so that ringing does not cause a false turn-off. A duty-cycle monitor with hysteresis stops the output at light load. Finally, a run level and a supply-good flag gate the whole block. When either of these drops, every stored measurement is discarded.

Top module: `sr_gate_timer`

## Requirements
- R1: While `rst_n` is low and on the first tick after release, `gate_on` is 0.
- R2: `gate_on` is 0 on every tick where `sr_clk_in` has been 1 for three or more consecutive ticks. This allows for the two-flop synchroniser and the edge tick, and a synchronised rising edge clears the gate at once.
- R3: The prediction P is the previous synchronised low phase length in ticks. The anticipation A comes from `ant_sel`: 0 gives 2, 1 gives 3, and 2 or 3 give 5. A gate pulse is high for exactly P-A consecutive ticks, starting one tick after the synchronised falling edge, and a pulse begins only from such an edge.
- R4: When P is less than or equal to A, no pulse is produced in that low phase.
- R5: No pulse is produced in the first low phase after reset, after a run-level drop or after a supply-good drop, because no prediction exists yet. Pulses resume in the low phase after that.
- R6: If the actual low phase is shorter than P-A+1 ticks, the pulse lasts until the synchronised rising edge and is high for (actual low length - 1) ticks.
- R7: `rev_flag` is ignored for the first 11 ticks of a pulse. When it is high on a later pulse tick, that tick is the last high tick, and the gate stays off for the rest of the phase.
- R8: At each synchronised rising edge that closes a complete high-then-low measurement, the high fraction H/(H+L) is evaluated. If it is below 14 percent, the output is shut down from the next low phase on.
- R9: A shutdown is lifted only when the fraction exceeds 19 percent. Fractions between the two limits keep the current state, whether the output is running or shut down.
- R10: `run_en` low ends any pulse after the current tick, blocks further pulses, and clears the prediction and the shutdown state.
- R11: `uv_ok` low has the same effect as `run_en` low.
- R12: Phase counters saturate at 2^CNT_W-1 (1023 by default) and never wrap. A saturated prediction gives a pulse of 1023-A ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast tick clock (about 15 MHz) |
| rst_n | input | 1 | Asynchronous active-low reset |
| sr_clk_in | input | 1 | Digitised rectifier clock; high while the primary conducts |
| ant_sel | input | 2 | Anticipation select (2, 3, 5, 5 ticks) |
| rev_flag | input | 1 | Reverse-current comparator flag; 1 means the current is reversing |
| run_en | input | 1 | Run level; 0 forces the gate off |
| uv_ok | input | 1 | Supply-good flag; 0 forces the gate off |
| gate_on | output | 1 | Gate enable for the rectifier driver |

## Verification
Two of the block's functions can end a pulse on the same tick: the anticipation count reaching its target, and a reverse-current flag that is honoured after blanking. The bench provokes this with a 5-tick anticipation on a 60-tick low phase. It raises the flag on the exact input tick that maps to the 55th gate tick, and also one tick earlier. The pulse is judged by its width: 55 ticks when the two stops coincide, and 54 when the flag comes first. A double stop must neither extend nor shorten the pulse. The bench also lets a run-level drop land inside a pulse, and lets a saturated prediction meet a short real phase, so that the rising-edge cut and the anticipation target compete.

// File: rtl/sr_pkg.sv
`timescale 1ns/1ps
package sr_pkg;
  typedef enum logic [1:0] {
    ANT_SHORT    = 2'd0,
    ANT_MID      = 2'd1,
    ANT_LONG     = 2'd2,
    ANT_LONG_ALT = 2'd3
  } ant_sel_e;

  typedef struct packed {
    logic lvl;   // synchronised clock level
    logic rise;  // first tick of a high phase
    logic fall;  // first tick of a low phase
  } edge_t;
endpackage

// File: rtl/sr_sync_edge.sv
`timescale 1ns/1ps
module sr_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          async_in,
  output sr_pkg::edge_t ev
);
  // chain[STAGES-1] is the synchronised level, chain[STAGES] its last value
  logic [STAGES:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-1:0], async_in};
  end

  always_comb begin
    ev.lvl  = chain[STAGES-1];
    ev.rise = chain[STAGES-1] & ~chain[STAGES];
    ev.fall = ~chain[STAGES-1] & chain[STAGES];
  end
endmodule

// File: rtl/sr_phase_meter.sv
`timescale 1ns/1ps
module sr_phase_meter #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  sr_pkg::edge_t    ev,
  output logic [CNT_W-1:0] lo_cnt,
  output logic [CNT_W-1:0] pred,
  output logic             pred_ok,
  output logic [CNT_W-1:0] hi_len,
  output logic             hi_ok,
  output logic             lo_seen
);
  localparam logic [CNT_W-1:0] CMAX = '1;
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  logic [CNT_W-1:0] hi_cnt;
  logic             hi_seen;

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
    return (v == CMAX) ? v : v + ONE;
  endfunction

  // phase counters run regardless of clear; only validity is reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_cnt <= '0;
      hi_cnt <= '0;
    end else begin
      if (ev.fall)      lo_cnt <= ONE;
      else if (!ev.lvl) lo_cnt <= sat_inc(lo_cnt);
      if (ev.rise)      hi_cnt <= ONE;
      else if (ev.lvl)  hi_cnt <= sat_inc(hi_cnt);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_seen <= 1'b0;
      hi_seen <= 1'b0;
      pred    <= '0;
      pred_ok <= 1'b0;
      hi_len  <= '0;
      hi_ok   <= 1'b0;
    end else if (clear) begin
      lo_seen <= 1'b0;
      hi_seen <= 1'b0;
      pred_ok <= 1'b0;
      hi_ok   <= 1'b0;
    end else begin
      if (ev.fall) begin
        lo_seen <= 1'b1;
        hi_len  <= hi_cnt;
        hi_ok   <= hi_seen;
      end
      if (ev.rise) begin
        hi_seen <= 1'b1;
        pred    <= lo_cnt;
        pred_ok <= lo_seen;
      end
    end
  end
endmodule

// File: rtl/sr_duty_guard.sv
`timescale 1ns/1ps
module sr_duty_guard #(
  parameter int CNT_W   = 10,
  parameter int OFF_PCT = 14,
  parameter int ON_PCT  = 19
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             rise,
  input  logic [CNT_W-1:0] hi_len,
  input  logic [CNT_W-1:0] lo_len,
  input  logic             hi_ok,
  input  logic             lo_seen,
  output logic             shut
);
  localparam int PW = CNT_W + 8;

  logic [PW-1:0] hi_scaled, period, off_lim, on_lim;
  logic          eval;

  always_comb begin
    hi_scaled = PW'(hi_len) * PW'(100);
    period    = PW'(hi_len) + PW'(lo_len);
    off_lim   = period * PW'(OFF_PCT);
    on_lim    = period * PW'(ON_PCT);
    eval      = rise & hi_ok & lo_seen;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           shut <= 1'b0;
    else if (clear)                       shut <= 1'b0;
    else if (eval && !shut && hi_scaled < off_lim) shut <= 1'b1;
    else if (eval &&  shut && hi_scaled > on_lim)  shut <= 1'b0;
  end
endmodule

// File: rtl/sr_gate_ctrl.sv
`timescale 1ns/1ps
module sr_gate_ctrl #(
  parameter int CNT_W   = 10,
  parameter int ANT_T0  = 2,
  parameter int ANT_T1  = 3,
  parameter int ANT_T2  = 5,
  parameter int BLANK_T = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  sr_pkg::edge_t    ev,
  input  logic [1:0]       ant_sel,
  input  logic             rev_flag,
  input  logic             run_ok,
  input  logic             shut,
  input  logic [CNT_W-1:0] pred,
  input  logic             pred_ok,
  input  logic [CNT_W-1:0] lo_cnt,
  output logic             gate_q
);
  import sr_pkg::*;
  localparam int BW = $clog2(BLANK_T + 1);

  logic [CNT_W-1:0] ant_v, tgt;
  logic [BW-1:0]    blank;
  logic             arm, stop;

  function automatic logic [CNT_W-1:0] ant_ticks(input ant_sel_e sel);
    case (sel)
      ANT_SHORT: return CNT_W'(ANT_T0);
      ANT_MID:   return CNT_W'(ANT_T1);
      default:   return CNT_W'(ANT_T2);
    endcase
  endfunction

  always_comb begin
    ant_v = ant_ticks(ant_sel_e'(ant_sel));
    arm   = ev.fall & run_ok & ~shut & pred_ok & (pred > ant_v);
    stop  = ev.rise | ~run_ok | (lo_cnt >= tgt) | (rev_flag & (blank == '0));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q <= 1'b0;
      tgt    <= '0;
      blank  <= '0;
    end else if (ev.fall) begin
      gate_q <= arm;
      tgt    <= pred - ant_v;
      blank  <= BW'(BLANK_T);
    end else if (gate_q) begin
      if (stop)          gate_q <= 1'b0;
      if (blank != '0)   blank  <= blank - BW'(1);
    end
  end
endmodule

// File: rtl/sr_gate_timer.sv
`timescale 1ns/1ps
module sr_gate_timer #(
  parameter int CNT_W        = 10,
  parameter int SYNC_STAGES  = 2,
  parameter int ANT_T0       = 2,
  parameter int ANT_T1       = 3,
  parameter int ANT_T2       = 5,
  parameter int BLANK_T      = 11,
  parameter int DUTY_OFF_PCT = 14,
  parameter int DUTY_ON_PCT  = 19
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sr_clk_in,
  input  logic [1:0] ant_sel,
  input  logic       rev_flag,
  input  logic       run_en,
  input  logic       uv_ok,
  output logic       gate_on
);
  sr_pkg::edge_t    ev;
  logic             run_ok, shut, pred_ok, hi_ok, lo_seen, gate_q;
  logic [CNT_W-1:0] lo_cnt, pred, hi_len;

  assign run_ok = run_en & uv_ok;

  sr_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(sr_clk_in), .ev(ev)
  );

  sr_phase_meter #(.CNT_W(CNT_W)) u_meter (
    .clk(clk), .rst_n(rst_n), .clear(~run_ok), .ev(ev),
    .lo_cnt(lo_cnt), .pred(pred), .pred_ok(pred_ok),
    .hi_len(hi_len), .hi_ok(hi_ok), .lo_seen(lo_seen)
  );

  sr_duty_guard #(.CNT_W(CNT_W), .OFF_PCT(DUTY_OFF_PCT), .ON_PCT(DUTY_ON_PCT)) u_duty (
    .clk(clk), .rst_n(rst_n), .clear(~run_ok), .rise(ev.rise),
    .hi_len(hi_len), .lo_len(lo_cnt), .hi_ok(hi_ok), .lo_seen(lo_seen),
    .shut(shut)
  );

  sr_gate_ctrl #(.CNT_W(CNT_W), .ANT_T0(ANT_T0), .ANT_T1(ANT_T1),
                 .ANT_T2(ANT_T2), .BLANK_T(BLANK_T)) u_gate (
    .clk(clk), .rst_n(rst_n), .ev(ev), .ant_sel(ant_sel), .rev_flag(rev_flag),
    .run_ok(run_ok), .shut(shut), .pred(pred), .pred_ok(pred_ok),
    .lo_cnt(lo_cnt), .gate_q(gate_q)
  );

  // a synchronised high level masks the gate on the very tick it appears
  assign gate_on = gate_q & ~ev.lvl;
endmodule

// File: rtl/sr_gate_timer_chk.sv
`timescale 1ns/1ps
module sr_gate_timer_chk #(
  parameter int CNT_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lvl,
  input logic             rise,
  input logic             fall,
  input logic             gate_on,
  input logic             run_en,
  input logic             uv_ok,
  input logic             pred_ok,
  input logic             shut,
  input logic [CNT_W-1:0] lo_cnt
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  AST_HIGH_LEVEL_GATE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl && !rise) |-> !gate_on); // R2
  AST_ON_ONLY_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_on) |-> $past(fall)); // R3
  AST_NO_PRED_NO_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (fall && !pred_ok) |=> !gate_on); // R5
  AST_SHUT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (fall && shut) |=> !gate_on); // R8
  AST_RUN_DROP_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> !gate_on); // R10
  AST_UV_DROP_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !uv_ok |=> !gate_on); // R11
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_cnt == CMAX && !lvl && !fall) |=> (lo_cnt == CMAX)); // R12
endmodule

bind sr_gate_timer sr_gate_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .lvl(ev.lvl), .rise(ev.rise), .fall(ev.fall),
  .gate_on(gate_on), .run_en(run_en), .uv_ok(uv_ok), .pred_ok(pred_ok),
  .shut(shut), .lo_cnt(lo_cnt)
);

// File: tb/sr_gate_timer_bench.sv
`timescale 1ns/1ps
module sr_gate_timer_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sr_clk_in = 1'b1;
  logic [1:0] ant_sel = 2'd0;
  logic       rev_flag = 1'b0;
  logic       run_en = 1'b1;
  logic       uv_ok = 1'b1;
  logic       gate_on;

  int n_chk = 0, n_bad = 0;
  int gcnt = 0, hi_run = 0, viol = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sr_gate_timer u_sr_gate_timer (
    .clk(clk), .rst_n(rst_n), .sr_clk_in(sr_clk_in), .ant_sel(ant_sel),
    .rev_flag(rev_flag), .run_en(run_en), .uv_ok(uv_ok), .gate_on(gate_on)
  );

  // monitor sampled at the falling clock edge
  always @(negedge clk) begin
    if (gate_on) gcnt++;
    if (sr_clk_in) hi_run++; else hi_run = 0;
    if (gate_on && hi_run >= 3) viol++;
  end

  task automatic expect_eq(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  // one low phase then one high phase; counts gate ticks of that low phase
  task automatic run_phase(input int lo, input int hi, input int rev_lo, input int rev_hi,
                           input int off_at, input int exp, input string tag);
    int snap;
    snap = gcnt;
    for (int j = 1; j <= lo; j++) begin
      @(posedge clk); #3;
      sr_clk_in = 1'b0;
      rev_flag  = (j >= rev_lo && j <= rev_hi);
      if (j == off_at) run_en = 1'b0;
    end
    for (int j = 1; j <= hi; j++) begin
      @(posedge clk); #3;
      sr_clk_in = 1'b1;
      rev_flag  = 1'b0;
    end
    expect_eq(tag, gcnt - snap, exp);
  endtask

  task automatic plain(input int lo, input int hi, input int exp, input string tag);
    run_phase(lo, hi, 0, -1, 0, exp, tag);
  endtask

  // clear history, then one unpredicted phase of length lo
  task automatic prime(input int lo);
    run_en = 1'b0;
    plain(60, 40, 0, "R10 restart");
    run_en = 1'b1;
    plain(lo, 40, 0, "R5 first phase");
  endtask

  task automatic t_reset();
    repeat (4) @(posedge clk);
    #3 expect_eq("R1 gate in reset", int'(gate_on), 0);
    rst_n = 1'b1;
    @(posedge clk); #3;
    expect_eq("R1 gate after release", int'(gate_on), 0);
    repeat (10) @(posedge clk);
    #3;
    plain(60, 40, 0, "R5 no prediction after reset");
    plain(60, 40, 58, "R3 second phase");
  endtask

  task automatic t_anticipation();
    prime(60);
    ant_sel = 2'd0; plain(60, 40, 58, "R3 sel0");
    ant_sel = 2'd1; plain(60, 40, 57, "R3 sel1");
    ant_sel = 2'd2; plain(60, 40, 55, "R3 sel2");
    ant_sel = 2'd3; plain(60, 40, 55, "R3 sel3");
    ant_sel = 2'd0;
  endtask

  task automatic t_rise_cut();
    prime(60);
    plain(30, 40, 29, "R6 short phase cut by rise");
    plain(30, 40, 28, "R3 new prediction");
  endtask

  task automatic t_small_pred();
    ant_sel = 2'd2;
    prime(5);
    plain(6, 40, 0, "R4 pred equals anticipation");
    plain(60, 40, 1, "R4 pred one above");
    ant_sel = 2'd0;
  endtask

  task automatic t_inhibit();
    prime(60);
    run_phase(60, 40, 1, 60, 0, 12, "R7 reverse held whole phase");
    run_phase(60, 40, 1, 8, 0, 58, "R7 reverse inside blanking");
    run_phase(60, 40, 30, 60, 0, 27, "R7 reverse after blanking");
  endtask

  task automatic t_coincide();
    ant_sel = 2'd2;
    prime(60);
    run_phase(60, 40, 58, 60, 0, 55, "R7 reverse on target tick");
    run_phase(60, 40, 57, 60, 0, 54, "R7 reverse one tick earlier");
    ant_sel = 2'd0;
  endtask

  task automatic t_duty();
    prime(60);
    plain(60, 16, 58, "R3 duty 40pct");
    plain(84, 8, 58, "R9 16pct keeps running");
    plain(92, 16, 82, "R9 running at 16pct");
    plain(84, 40, 0, "R8 shut after 8pct");
    plain(60, 40, 0, "R9 16pct keeps shut");
    plain(60, 40, 58, "R9 resumed after 40pct");
  endtask

  task automatic t_disable();
    prime(60);
    plain(60, 40, 58, "R3 before disable");
    run_phase(60, 40, 0, -1, 20, 17, "R10 drop inside pulse");
    plain(60, 40, 0, "R10 held off");
    run_en = 1'b1;
    plain(60, 40, 0, "R5 after run restored");
    plain(60, 40, 58, "R10 running again");
  endtask

  task automatic t_uvlo();
    prime(60);
    uv_ok = 1'b0;
    plain(60, 40, 0, "R11 supply low");
    uv_ok = 1'b1;
    plain(60, 40, 0, "R5 after supply good");
    plain(60, 40, 58, "R11 running again");
  endtask

  task automatic t_saturate();
    prime(60);
    plain(60, 600, 58, "R3 before long phase");
    plain(1500, 600, 58, "R12 long phase");
    plain(1100, 600, 1021, "R12 saturated prediction");
    plain(60, 40, 59, "R12 saturated prediction cut");
    plain(60, 40, 58, "R3 back to normal");
  endtask

  initial begin
    t_reset();
    t_anticipation();
    t_rise_cut();
    t_small_pred();
    t_inhibit();
    t_coincide();
    t_duty();
    t_disable();
    t_uvlo();
    t_saturate();
    expect_eq("R2 gate while clock high", viol, 0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule